// File: doc/BRIEF.md
# Parallel DAC Host Bus Sequencer

This block sits on the host side of a 16-bit double-buffered parallel converter and turns single commands into correctly ordered pin activity. A command (write a word, read the input register back, strobe the load line, or reset the converter) is accepted on a valid/ready port. The block then walks the chip-select, direction, data-bus, load and reset pins through setup, pulse and hold phases. The length of each phase is a parameter counted in clock cycles, and each is at least one cycle.

A combined verify command writes a word and reads it back. It raises the load strobe only when the word read back equals the word written. On a difference it reports a mismatch and leaves the converter output untouched. Every command ends with a one-cycle response pulse that carries the last word read and the mismatch flag. Because the load strobe is a plain output, it can be wired to several converters for a common update.

Top module: `dac_bus_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, `bus_cs_n`=1, `bus_rw`=1, `bus_oe`=1, `bus_ld`=0, `bus_rst_n`=1, `cmd_ready`=1 and `rsp_valid`=0.
- R2: For a write, `bus_rw` is low and `bus_dout` carries the command word for at least T_SETUP cycles before `bus_cs_n` falls. `bus_cs_n` then stays low for exactly T_CS cycles, and `bus_rw` stays low for at least T_HOLD cycles after `bus_cs_n` rises.
- R3: For a read, `bus_rw` is high and `bus_oe` is low for at least T_SETUP cycles before `bus_cs_n` falls. `bus_cs_n` stays low for exactly T_CS cycles, and `bus_din` is captured on its last low cycle and returned in `rsp_data`. `bus_oe` stays low for at least T_REL cycles after `bus_cs_n` rises.
- R4: A load raises `bus_ld` for exactly T_LD cycles. There are at least T_LSP cycles between any chip-select edge and the next load-strobe edge, and between the load strobe falling and the next chip-select fall.
- R5: A reset command copies `cmd_rsel` to `bus_rsel` at least T_RSU cycles before `bus_rst_n` falls, and then holds `bus_rst_n` low for exactly T_RST cycles. `bus_rsel` stays unchanged while reset is low and for at least T_RSU cycles after it rises.
- R6: A verify command whose read-back equals the written word performs write, read and load in that order. It responds with `rsp_mismatch`=0 and `rsp_data` equal to the word read.
- R7: A verify command whose read-back differs performs the write and the read, produces no `bus_ld` pulse, and responds with `rsp_mismatch`=1.
- R8: `cmd_op` encodes 0=write, 1=read, 2=load, 3=reset and 4=verify. A command is taken when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while no command is in progress. Each command yields exactly one `rsp_valid` pulse. Codes 5 to 7 produce the response pulse with no chip-select, load or reset activity.
- R9: `bus_cs_n` low and `bus_ld` high never coincide. The host never drives the bus (`bus_oe`=1) while a read has chip select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 3 | Command code (see R8) |
| cmd_data | input | 16 | Word to write |
| cmd_rsel | input | 1 | Reset target: 1 mid-scale, 0 min-scale |
| rsp_valid | output | 1 | One-cycle end-of-command pulse |
| rsp_data | output | 16 | Last word read from the converter |
| rsp_mismatch | output | 1 | Verify read-back differed |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw | output | 1 | Direction: 1 read, 0 write |
| bus_dout | output | 16 | Data driven toward the converter |
| bus_oe | output | 1 | Host bus driver enable |
| bus_din | input | 16 | Data returned by the converter |
| bus_ld | output | 1 | Load strobe, converter updates on its rise |
| bus_rst_n | output | 1 | Converter reset, active low |
| bus_rsel | output | 1 | Reset target select |

## Verification
Two functions can meet in the same cycle. The end of the read-back release window is the cycle in which the verify compare decides whether the load phase follows. A chip-select edge and a load-strobe edge can also fall close together when a verify with a matching word moves straight into its load. The bench provokes this with verify commands, some of which have the model converter corrupt one bit of the returned word. Two independent measures judge the outcome: the bench counts cycles between every chip-select, load and reset edge, and it compares the model converter's two registers with values predicted from the command stream alone.

// File: rtl/dbs_pkg.sv
// Package: shared command codes and sequencer phases.
// Assumes the command field is three bits wide.
package dbs_pkg;
    localparam logic [2:0] OP_WRITE  = 3'd0;
    localparam logic [2:0] OP_READ   = 3'd1;
    localparam logic [2:0] OP_LOAD   = 3'd2;
    localparam logic [2:0] OP_RESET  = 3'd3;
    localparam logic [2:0] OP_VERIFY = 3'd4;

    typedef enum logic [3:0] {
        PH_IDLE, PH_WSU, PH_WCS, PH_WHD,
        PH_RSU, PH_RCS, PH_REL,
        PH_LSU, PH_LHI, PH_LGP,
        PH_XSU, PH_XLO, PH_XHD,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/dbs_delay.sv
// Phase timer: a down counter loaded with (length-1) at each phase entry.
// Assumes the load value fits CW bits; zero flags the last cycle of a phase.
module dbs_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Count down toward zero and reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R2 / R4 phase lengths depend on a strict one-per-cycle decrement.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dbs_rdcap.sv
// Read-back capture: holds the word sampled at the end of a read pulse
// and compares it with the word last written. Assumes capture is one cycle.
module dbs_rdcap #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          match
);
    // Register the converter's returned word.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (capture) rdata <= din;
    end

    assign match = (rdata == wdata);
endmodule

// File: rtl/dac_bus_seq.sv
// Host-side sequencer for a double-buffered parallel DAC bus.
// Takes one command at a time and walks the pins through timed phases.
// Assumes every timing parameter is at least 1 and below 2**CW.
module dac_bus_seq
    import dbs_pkg::*;
#(
    parameter int DW      = 16,
    parameter int CW      = 8,
    parameter int T_SETUP = 2,
    parameter int T_CS    = 3,
    parameter int T_HOLD  = 2,
    parameter int T_REL   = 2,
    parameter int T_LSP   = 1,
    parameter int T_LD    = 2,
    parameter int T_RSU   = 2,
    parameter int T_RST   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    input  logic          cmd_rsel,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_mismatch,
    output logic          bus_cs_n,
    output logic          bus_rw,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_din,
    output logic          bus_ld,
    output logic          bus_rst_n,
    output logic          bus_rsel
);
    phase_e        ph, next_ph;
    logic [2:0]    op_q;
    logic [DW-1:0] wdata_q;
    logic          rsel_q, mism_q;
    logic          zero, match, accept, advance;
    logic [CW-1:0] next_len;

    // Length of a phase in cycles, minus one, as loaded into the timer.
    function automatic logic [CW-1:0] ph_len(phase_e p);
        int v;
        case (p)
            PH_WSU, PH_RSU: v = T_SETUP;
            PH_WCS, PH_RCS: v = T_CS;
            PH_WHD:         v = T_HOLD;
            PH_REL:         v = T_REL;
            PH_LSU, PH_LGP: v = T_LSP;
            PH_LHI:         v = T_LD;
            PH_XSU, PH_XHD: v = T_RSU;
            PH_XLO:         v = T_RST;
            default:        v = 1;
        endcase
        return CW'(v - 1);
    endfunction

    assign cmd_ready = (ph == PH_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign advance   = (ph == PH_IDLE) ? accept : zero;
    assign next_len  = ph_len(next_ph);

    dbs_delay #(.CW(CW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (next_len),
        .zero     (zero)
    );

    dbs_rdcap #(.DW(DW)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (ph == PH_RCS && zero),
        .din     (bus_din),
        .wdata   (wdata_q),
        .rdata   (rsp_data),
        .match   (match)
    );

    // Choose the phase that follows the current one.
    always_comb begin
        next_ph = ph;
        case (ph)
            PH_IDLE: begin
                case (cmd_op)
                    OP_WRITE, OP_VERIFY: next_ph = PH_WSU;
                    OP_READ:             next_ph = PH_RSU;
                    OP_LOAD:             next_ph = PH_LSU;
                    OP_RESET:            next_ph = PH_XSU;
                    default:             next_ph = PH_DONE;
                endcase
            end
            PH_WSU:  next_ph = PH_WCS;
            PH_WCS:  next_ph = PH_WHD;
            PH_WHD:  next_ph = (op_q == OP_VERIFY) ? PH_RSU : PH_DONE;
            PH_RSU:  next_ph = PH_RCS;
            PH_RCS:  next_ph = PH_REL;
            PH_REL:  next_ph = (op_q == OP_VERIFY && match) ? PH_LSU : PH_DONE;
            PH_LSU:  next_ph = PH_LHI;
            PH_LHI:  next_ph = PH_LGP;
            PH_LGP:  next_ph = PH_DONE;
            PH_XSU:  next_ph = PH_XLO;
            PH_XLO:  next_ph = PH_XHD;
            PH_XHD:  next_ph = PH_DONE;
            default: next_ph = PH_IDLE;
        endcase
    end

    // Phase register, stepped when the timer expires or a command arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)       ph <= PH_IDLE;
        else if (advance) ph <= next_ph;
    end

    // Command capture, reset-select latch and verify outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_WRITE;
            wdata_q <= '0;
            rsel_q  <= 1'b0;
            mism_q  <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= cmd_op;
                mism_q <= 1'b0;
                if (cmd_op == OP_WRITE || cmd_op == OP_VERIFY) wdata_q <= cmd_data;
                if (cmd_op == OP_RESET) rsel_q <= cmd_rsel;
            end
            if (ph == PH_REL && zero && op_q == OP_VERIFY) mism_q <= !match;
        end
    end

    assign bus_cs_n     = !(ph == PH_WCS || ph == PH_RCS);
    assign bus_rw       = !(ph == PH_WSU || ph == PH_WCS || ph == PH_WHD);
    assign bus_oe       = !(ph == PH_RSU || ph == PH_RCS || ph == PH_REL);
    assign bus_ld       = (ph == PH_LHI);
    assign bus_rst_n    = !(ph == PH_XLO);
    assign bus_rsel     = rsel_q;
    assign bus_dout     = wdata_q;
    assign rsp_valid    = (ph == PH_DONE);
    assign rsp_mismatch = mism_q;

    // R9: chip select and load strobe never overlap.
    a_r9_cs_ld_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_cs_n && bus_ld));
    // R9: no host drive during a read pulse.
    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_cs_n && bus_rw && bus_oe));
    // R2 / R3: direction never changes on a chip-select edge.
    a_r2_rw_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_cs_n) || $rose(bus_cs_n)) |-> $stable(bus_rw));
    // R3: driver already released the cycle before a read pulse starts.
    a_r3_released_early: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_cs_n) && bus_rw) |-> !$past(bus_oe));
    // R5: reset select steady around and during reset.
    a_r5_rsel_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rst_n || $rose(bus_rst_n) || $fell(bus_rst_n)) |-> $stable(bus_rsel));
    // R7: no load strobe after a failed compare.
    a_r7_no_ld_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ld |-> !mism_q);
    // R8: idle means no response and quiet control pins.
    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!rsp_valid && bus_cs_n && bus_rst_n && !bus_ld));
endmodule

// File: tb/dac_bus_seq_test.sv
module dac_bus_seq_test;
    localparam int DW = 16;
    localparam int T_SETUP = 2, T_CS = 3, T_HOLD = 2, T_REL = 2;
    localparam int T_LSP = 1, T_LD = 2, T_RSU = 2, T_RST = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_rsel = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [DW-1:0] cmd_data = '0;
    logic cmd_ready, rsp_valid, rsp_mismatch;
    logic [DW-1:0] rsp_data, bus_dout, bus_din;
    logic bus_cs_n, bus_rw, bus_oe, bus_ld, bus_rst_n, bus_rsel;

    always #4 clk = ~clk;

    dac_bus_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_rsel(cmd_rsel),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_mismatch(rsp_mismatch),
        .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din), .bus_ld(bus_ld), .bus_rst_n(bus_rst_n), .bus_rsel(bus_rsel)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // Converter model and edge-timing monitor.
    logic [DW-1:0] dev_in = '0, dev_dac = '0;
    bit corrupt = 1'b0;
    assign bus_din = corrupt ? (dev_in ^ 16'h0100) : dev_in;

    int cs_falls = 0, ld_rises = 0, rst_falls = 0;
    int rw_run = 1, cs_lo = 0, since_cs_rise = 100, since_cs_edge = 100;
    int since_ld_fall = 100, ld_hi = 0, rsel_run = 1, rst_lo = 0, since_rst_rise = 100;
    bit have_rst = 1'b0;
    logic p_cs = 1'b1, p_rw = 1'b1, p_oe = 1'b1, p_ld = 1'b0, p_rst = 1'b1, p_rsel = 1'b0;
    logic [DW-1:0] p_dout = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            rw_run   = (bus_rw == p_rw) ? rw_run + 1 : 1;
            rsel_run = (bus_rsel == p_rsel) ? rsel_run + 1 : 1;
            if (p_cs && !bus_cs_n) begin
                cs_falls++;
                chk(rw_run - 1 >= T_SETUP, bus_rw ? "R3 setup" : "R2 setup", rw_run - 1, T_SETUP);
                chk(since_ld_fall - 1 >= T_LSP, "R4 ld-to-cs", since_ld_fall - 1, T_LSP);
                if (bus_rw) chk(!p_oe, "R3 release", p_oe, 0);
                else        chk(bus_oe, "R2 drive", bus_oe, 1);
            end
            if (!bus_cs_n) cs_lo++;
            if (!p_cs && bus_cs_n) begin
                chk(cs_lo == T_CS, "R2/R3 cs width", cs_lo, T_CS);
                cs_lo = 0;
                since_cs_rise = 0;
                if (!p_rw) dev_in = p_dout;
            end
            if (p_cs != bus_cs_n) since_cs_edge = 1; else since_cs_edge++;
            if (bus_cs_n) since_cs_rise++;
            if (!p_rw && bus_rw) chk(since_cs_rise - 1 >= T_HOLD, "R2 hold", since_cs_rise - 1, T_HOLD);
            if (!p_oe && bus_oe) chk(since_cs_rise - 1 >= T_REL, "R3 release time", since_cs_rise - 1, T_REL);
            if (!p_ld && bus_ld) begin
                ld_rises++;
                chk(since_cs_edge - 1 >= T_LSP, "R4 cs-to-ld", since_cs_edge - 1, T_LSP);
                dev_dac = dev_in;
            end
            if (bus_ld) ld_hi++;
            if (p_ld && !bus_ld) begin
                chk(ld_hi == T_LD, "R4 ld width", ld_hi, T_LD);
                ld_hi = 0;
                since_ld_fall = 0;
            end
            since_ld_fall++;
            if (p_rst && !bus_rst_n) begin
                rst_falls++;
                chk(rsel_run - 1 >= T_RSU, "R5 rsel setup", rsel_run - 1, T_RSU);
            end
            if (!bus_rst_n) begin
                rst_lo++;
                dev_in  = bus_rsel ? 16'h8000 : 16'h0000;
                dev_dac = dev_in;
            end
            if (!p_rst && bus_rst_n) begin
                chk(rst_lo == T_RST, "R5 rst width", rst_lo, T_RST);
                rst_lo = 0;
                since_rst_rise = 0;
                have_rst = 1'b1;
            end
            since_rst_rise++;
            if (have_rst && p_rsel != bus_rsel)
                chk(since_rst_rise - 1 >= T_RSU, "R5 rsel hold", since_rst_rise - 1, T_RSU);
        end
        p_cs = bus_cs_n; p_rw = bus_rw; p_oe = bus_oe; p_ld = bus_ld;
        p_rst = bus_rst_n; p_rsel = bus_rsel; p_dout = bus_dout;
    end

    // Expected converter state, computed from the command stream only.
    logic [DW-1:0] exp_in = '0, exp_dac = '0;

    task automatic do_cmd(input logic [2:0] op, input logic [DW-1:0] d, input bit rs, input bit bad);
        int cf, lr, rf;
        logic [DW-1:0] exp_rd;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cf = cs_falls; lr = ld_rises; rf = rst_falls;
        corrupt = bad;
        cmd_op = op; cmd_data = d; cmd_rsel = rs; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready, "R8 busy after accept", cmd_ready, 0);
        while (!rsp_valid) @(negedge clk);
        case (op)
            3'd0: exp_in = d;
            3'd1: begin
                exp_rd = bad ? (exp_in ^ 16'h0100) : exp_in;
                chk(rsp_data == exp_rd, "R3 read data", rsp_data, exp_rd);
            end
            3'd2: exp_dac = exp_in;
            3'd3: begin exp_in = rs ? 16'h8000 : 16'h0000; exp_dac = exp_in; end
            3'd4: begin
                exp_in = d;
                exp_rd = bad ? (d ^ 16'h0100) : d;
                chk(rsp_data == exp_rd, "R6 verify data", rsp_data, exp_rd);
                if (bad) begin
                    chk(rsp_mismatch == 1'b1, "R7 mismatch flag", rsp_mismatch, 1);
                    chk(ld_rises == lr, "R7 no load", ld_rises - lr, 0);
                end else begin
                    exp_dac = d;
                    chk(rsp_mismatch == 1'b0, "R6 match flag", rsp_mismatch, 0);
                    chk(ld_rises == lr + 1, "R6 one load", ld_rises - lr, 1);
                end
            end
            default: chk(cs_falls == cf && ld_rises == lr && rst_falls == rf,
                         "R8 undefined op quiet", cs_falls - cf + ld_rises - lr + rst_falls - rf, 0);
        endcase
        @(negedge clk);
        corrupt = 1'b0;
        chk(!rsp_valid, "R8 single response", rsp_valid, 0);
        chk(dev_in == exp_in, "R2/R5 input reg", dev_in, exp_in);
        chk(dev_dac == exp_dac, "R4/R5 output reg", dev_dac, exp_dac);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({bus_cs_n, bus_rw, bus_oe, bus_ld, bus_rst_n, rsp_valid} == 6'b111010, "R1 in reset",
            {bus_cs_n, bus_rw, bus_oe, bus_ld, bus_rst_n, rsp_valid}, 6'b111010);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bus_cs_n, bus_rw, bus_oe, bus_ld, bus_rst_n, cmd_ready} == 6'b111011, "R1 after reset",
            {bus_cs_n, bus_rw, bus_oe, bus_ld, bus_rst_n, cmd_ready}, 6'b111011);
        // R5 reset to mid then min scale, R3 readback of each
        do_cmd(3'd3, '0, 1'b1, 1'b0);
        do_cmd(3'd1, '0, 1'b0, 1'b0);
        do_cmd(3'd3, '0, 1'b0, 1'b0);
        do_cmd(3'd1, '0, 1'b0, 1'b0);
        // R2 write extremes, R4 load
        do_cmd(3'd0, 16'hFFFF, 1'b0, 1'b0);
        do_cmd(3'd1, '0, 1'b0, 1'b0);
        do_cmd(3'd2, '0, 1'b0, 1'b0);
        do_cmd(3'd0, 16'h0000, 1'b0, 1'b0);
        do_cmd(3'd2, '0, 1'b0, 1'b0);
        // R6 / R7 verify with and without corruption
        do_cmd(3'd4, 16'h1234, 1'b0, 1'b0);
        do_cmd(3'd4, 16'hBEEF, 1'b0, 1'b1);
        do_cmd(3'd4, 16'h8001, 1'b0, 1'b0);
        // R8 undefined codes
        do_cmd(3'd5, 16'hAAAA, 1'b1, 1'b0);
        do_cmd(3'd7, 16'h5555, 1'b1, 1'b0);
        // Random mix
        for (int i = 0; i < 80; i++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 6));
            do_cmd(op, 16'($urandom), 1'($urandom), (op == 3'd1 || op == 3'd4) && ($urandom_range(0, 3) == 0));
        end
        finish_run();
    end
endmodule